// File: doc/BRIEF.md
# Bus Access Permission Filter

This block decides whether a bus access to one of a set of peripheral regions is allowed. Each access presents the identity of the requesting master (core 0, core 1, DMA engine or debugger), whether it is secure, whether it is privileged, and the index of the target region. The block answers with a grant in the same cycle, using a permission byte held for that region. The grant is purely combinational from the access inputs and the stored state.

Each permission byte holds two masks. The master mask says which masters may reach the region. The security mask says which combinations of security and privilege may reach it. Inside the security mask, each unprivileged bit only counts when the privileged bit of the same security class is also set.

The permission bytes sit in a small configuration register file with a write/read port, which also holds three more registers. The first is a per-master sticky lock that silently drops configuration writes from a locked master. The second is a force register that makes core 1 always count as non-secure. The third is a write-one configuration reset that restores every permission byte to its default and leaves the lock and force registers alone. The number of regions and each region's default class are parameters.

Top module: `bus_perm_filter`

## Requirements
- R1: An access to an in-range region is granted in the same cycle only when the region's byte has the master's bit set and also has the security/privilege bit for the access set. The master bits are bit 4 for core 0, bit 5 for core 1, bit 6 for DMA and bit 7 for debugger. The security/privilege bits are bit 3 for secure privileged, bit 2 for secure unprivileged, bit 1 for non-secure privileged and bit 0 for non-secure unprivileged. Master codes are 0 for core 0, 1 for core 1, 2 for DMA and 3 for debugger.
- R2: A secure unprivileged access needs both bit 2 and bit 3 set. A non-secure unprivileged access needs both bit 0 and bit 1 set.
- R3: An access whose region index is NUM_REGIONS or above is always denied.
- R4: After reset each permission byte takes the default of its class, chosen by 2 bits per region in REGION_CLASS (region i at bits 2i+1:2i). The class codes are: 0 gives 0xFF, 1 gives 0xFC, 2 gives 0xB8 and 3 gives 0x00. The default map gives regions 0 and 1 class 0, regions 2 to 4 class 1, and regions 5 to 7 class 2.
- R5: The lock register holds bit 0 for core 0, bit 1 for core 1, bit 2 for DMA and bit 3 for debugger, and resets to 0x04. Any configuration write from a master whose lock bit is 1 changes nothing and raises no error.
- R6: Lock bits are sticky. A write ORs the written bits into the register, so writing 0 clears nothing, and only the system reset clears a lock bit.
- R7: The force register stores only bit 1 and resets to 0. While bit 1 is set, every access from core 1 is judged as non-secure whatever security flag it carries; other masters are unaffected.
- R8: A write with bit 0 set to the configuration reset register restores all permission bytes to their defaults on the clock edge after the write. The lock and force registers are unchanged. When that restore coincides with a permission write, the restore wins. A write of 0 to this register does nothing.
- R9: The configuration address map is: addresses 0 to NUM_REGIONS-1 hold the permission bytes, NUM_REGIONS holds the lock register, NUM_REGIONS+1 holds the force register and NUM_REGIONS+2 holds the configuration reset register. Reads are combinational and return current values with unused bits as zero. The configuration reset register and all unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| accMaster | input | 2 | Master code of the access under check |
| accSecure | input | 1 | 1 for a secure access |
| accPriv | input | 1 | 1 for a privileged access |
| accRegion | input | clog2(NUM_REGIONS)+1 (4) | Target region index |
| accGrant | output | 1 | 1 when the access is allowed |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMaster | input | 2 | Master code of the configuration writer |
| cfgAddr | input | clog2(NUM_REGIONS+3) (4) | Configuration register address, for reads and writes |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for cfgAddr |

## Verification
Permission bytes are read back at the port, so a wrong byte shows up there. It also shows in the very next grant decision for that region, because the grant path has no register. A lock bit that clears, or a locked write that slips through, shows up at the lock, force or permission readback on the cycle after the write. A configuration reset that lands on the wrong edge is caught by reading a permission byte both between the write and the restore and right after the restore. Exhaustive sweeps over master, security, privilege and region, run after every change of state, catch a wrong force or dependency rule on the cycle the access is presented.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  localparam int PERM_W = 8;
  localparam int MASTER_N = 4;

  // security/privilege bit positions inside a permission byte
  localparam int BIT_NS_UNPRIV = 0;
  localparam int BIT_NS_PRIV   = 1;
  localparam int BIT_S_UNPRIV  = 2;
  localparam int BIT_S_PRIV    = 3;

  typedef enum logic [1:0] {
    MST_CORE0 = 2'd0,
    MST_CORE1 = 2'd1,
    MST_DMA   = 2'd2,
    MST_DEBUG = 2'd3
  } master_e;

  typedef enum logic [1:0] {
    CLS_OPEN       = 2'd0,
    CLS_SECURE_ANY = 2'd1,
    CLS_RESTRICTED = 2'd2,
    CLS_CLOSED     = 2'd3
  } region_class_e;

  localparam logic [PERM_W-1:0] WORD_OPEN       = 8'hFF;
  localparam logic [PERM_W-1:0] WORD_SECURE_ANY = 8'hFC;
  localparam logic [PERM_W-1:0] WORD_RESTRICTED = 8'hB8;
  localparam logic [PERM_W-1:0] WORD_CLOSED     = 8'h00;

  // strobes from the control to the datapath
  typedef struct packed {
    logic permWe;      // write the addressed permission byte
    logic clearAll;    // restore all permission bytes to defaults
    logic forceCore1;  // level: core 1 judged non-secure
  } ctrl_strobe_t;

  function automatic logic [PERM_W-1:0] classDefault(input logic [1:0] cls);
    case (region_class_e'(cls))
      CLS_OPEN:       return WORD_OPEN;
      CLS_SECURE_ANY: return WORD_SECURE_ANY;
      CLS_RESTRICTED: return WORD_RESTRICTED;
      default:        return WORD_CLOSED;
    endcase
  endfunction

endpackage

// File: rtl/bpf_grant_eval.sv
module bpf_grant_eval
  import bpf_pkg::*;
(
  input  logic [PERM_W-1:0] word,
  input  logic              regionOk,
  input  logic [1:0]        master,
  input  logic              secure,
  input  logic              priv,
  input  logic              forceCore1,
  output logic              grant
);

  logic effSecure;
  logic masterOk;
  logic secOk;

  // core 1 loses its secure flag while the force bit is set
  assign effSecure = secure & ~(forceCore1 & (master_e'(master) == MST_CORE1));

  // master bits occupy 4..7, so index is {1, master}
  assign masterOk = word[{1'b1, master}];

  always_comb begin
    unique case ({effSecure, priv})
      2'b11:   secOk = word[BIT_S_PRIV];
      2'b10:   secOk = word[BIT_S_PRIV] & word[BIT_S_UNPRIV];
      2'b01:   secOk = word[BIT_NS_PRIV];
      default: secOk = word[BIT_NS_PRIV] & word[BIT_NS_UNPRIV];
    endcase
  end

  assign grant = regionOk & masterOk & secOk;

endmodule

// File: rtl/bpf_datapath.sv
module bpf_datapath
  import bpf_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter logic [2*NUM_REGIONS-1:0] REGION_CLASS = 16'hA950,
  localparam int IW  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int RIW = $clog2(NUM_REGIONS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [IW-1:0]     permIdx,
  input  logic [PERM_W-1:0] permData,
  output logic [PERM_W-1:0] permRdWord,
  input  logic [1:0]        accMaster,
  input  logic              accSecure,
  input  logic              accPriv,
  input  logic [RIW-1:0]    accRegion,
  output logic              accGrant
);

  logic [PERM_W-1:0] permQ [NUM_REGIONS];
  logic [PERM_W-1:0] accWord;
  logic              regionOk;

  // one register per region, each with its own class default
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [PERM_W-1:0] DEF = classDefault(REGION_CLASS[2*g +: 2]);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        permQ[g] <= DEF;
      end else if (strb.clearAll) begin
        // restore has priority over a coinciding write
        permQ[g] <= DEF;
      end else if (strb.permWe && (permIdx == IW'(g))) begin
        permQ[g] <= permData;
      end
    end
  end

  // configuration readback
  always_comb begin
    permRdWord = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (permIdx == IW'(i)) permRdWord = permQ[i];
    end
  end

  // access side selection
  assign regionOk = (accRegion < RIW'(NUM_REGIONS));

  always_comb begin
    accWord = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (accRegion == RIW'(i)) accWord = permQ[i];
    end
  end

  bpf_grant_eval u_eval (
    .word      (accWord),
    .regionOk  (regionOk),
    .master    (accMaster),
    .secure    (accSecure),
    .priv      (accPriv),
    .forceCore1(strb.forceCore1),
    .grant     (accGrant)
  );

endmodule

// File: rtl/bpf_ctrl.sv
module bpf_ctrl
  import bpf_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int AW = $clog2(NUM_REGIONS + 3)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgMaster,
  input  logic [AW-1:0]       cfgAddr,
  input  logic [PERM_W-1:0]   cfgWrData,
  output logic [PERM_W-1:0]   cfgRdData,
  input  logic [PERM_W-1:0]   permRdWord,
  output ctrl_strobe_t        strb,
  output logic [IW-1:0]       permIdx,
  output logic [PERM_W-1:0]   permData,
  output logic [MASTER_N-1:0] lockBits,
  output logic                forceBit
);

  localparam logic [AW-1:0] LOCK_A  = AW'(NUM_REGIONS);
  localparam logic [AW-1:0] FORCE_A = AW'(NUM_REGIONS + 1);
  localparam logic [AW-1:0] CLEAR_A = AW'(NUM_REGIONS + 2);
  localparam logic [MASTER_N-1:0] LOCK_RESET = 4'b0100;

  logic [MASTER_N-1:0] lockQ;
  logic                forceQ;
  logic                clearPend;
  logic                writeOk;
  logic                hitPerm;

  // writes from a locked master are dropped silently
  assign writeOk = cfgWrEn & ~lockQ[cfgMaster];
  assign hitPerm = (cfgAddr < LOCK_A);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= LOCK_RESET;
    end else if (writeOk && (cfgAddr == LOCK_A)) begin
      lockQ <= lockQ | cfgWrData[MASTER_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceQ <= 1'b0;
    end else if (writeOk && (cfgAddr == FORCE_A)) begin
      forceQ <= cfgWrData[1];
    end
  end

  // restore is registered: applied on the edge after the write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clearPend <= 1'b0;
    end else begin
      clearPend <= writeOk & (cfgAddr == CLEAR_A) & cfgWrData[0];
    end
  end

  always_comb begin
    strb            = '0;
    strb.permWe     = writeOk & hitPerm;
    strb.clearAll   = clearPend;
    strb.forceCore1 = forceQ;
  end

  assign permIdx  = cfgAddr[IW-1:0];
  assign permData = cfgWrData;
  assign lockBits = lockQ;
  assign forceBit = forceQ;

  always_comb begin
    cfgRdData = '0;
    if (hitPerm) begin
      cfgRdData = permRdWord;
    end else if (cfgAddr == LOCK_A) begin
      cfgRdData = {{(PERM_W-MASTER_N){1'b0}}, lockQ};
    end else if (cfgAddr == FORCE_A) begin
      cfgRdData = {{(PERM_W-2){1'b0}}, forceQ, 1'b0};
    end
  end

endmodule

// File: rtl/bus_perm_filter.sv
module bus_perm_filter
  import bpf_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter logic [2*NUM_REGIONS-1:0] REGION_CLASS = 16'hA950
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [1:0]                         accMaster,
  input  logic                               accSecure,
  input  logic                               accPriv,
  input  logic [$clog2(NUM_REGIONS):0]       accRegion,
  output logic                               accGrant,
  input  logic                               cfgWrEn,
  input  logic [1:0]                         cfgMaster,
  input  logic [$clog2(NUM_REGIONS+3)-1:0]   cfgAddr,
  input  logic [7:0]                         cfgWrData,
  output logic [7:0]                         cfgRdData
);

  localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  ctrl_strobe_t        strb;
  logic [IW-1:0]       permIdx;
  logic [PERM_W-1:0]   permData;
  logic [PERM_W-1:0]   permRdWord;
  logic [MASTER_N-1:0] lockBits;
  logic                forceBit;

  bpf_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgMaster (cfgMaster),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .permRdWord(permRdWord),
    .strb      (strb),
    .permIdx   (permIdx),
    .permData  (permData),
    .lockBits  (lockBits),
    .forceBit  (forceBit)
  );

  bpf_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_CLASS(REGION_CLASS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .permIdx   (permIdx),
    .permData  (permData),
    .permRdWord(permRdWord),
    .accMaster (accMaster),
    .accSecure (accSecure),
    .accPriv   (accPriv),
    .accRegion (accRegion),
    .accGrant  (accGrant)
  );

endmodule

// File: rtl/bpf_checker.sv
module bpf_checker #(
  parameter int NUM_REGIONS = 8,
  localparam int AW  = $clog2(NUM_REGIONS + 3),
  localparam int RIW = $clog2(NUM_REGIONS) + 1
) (
  input logic           clk,
  input logic           rstN,
  input logic [RIW-1:0] accRegion,
  input logic           accGrant,
  input logic           cfgWrEn,
  input logic [1:0]     cfgMaster,
  input logic [AW-1:0]  cfgAddr,
  input logic           wrForceBit,
  input logic [7:0]     cfgRdData,
  input logic [3:0]     lockBits,
  input logic           forceBit
);

  localparam logic [AW-1:0] LOCK_A  = AW'(NUM_REGIONS);
  localparam logic [AW-1:0] FORCE_A = AW'(NUM_REGIONS + 1);

  assert_oob_deny_R3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(accRegion) >= NUM_REGIONS) |-> !accGrant);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(lockBits) & ~lockBits) == 4'b0000));

  assert_locked_write_dropped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && lockBits[cfgMaster]) |=>
      ((lockBits == $past(lockBits)) && (forceBit == $past(forceBit))));

  assert_force_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !lockBits[cfgMaster] && (cfgAddr == FORCE_A)) |=>
      (forceBit == $past(wrForceBit)));

  assert_lock_readback_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == LOCK_A) |-> (cfgRdData == {4'b0000, lockBits}));

endmodule

bind bus_perm_filter bpf_checker #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .accRegion (accRegion),
  .accGrant  (accGrant),
  .cfgWrEn   (cfgWrEn),
  .cfgMaster (cfgMaster),
  .cfgAddr   (cfgAddr),
  .wrForceBit(cfgWrData[1]),
  .cfgRdData (cfgRdData),
  .lockBits  (lockBits),
  .forceBit  (forceBit)
);

// File: tb/bus_perm_filter_tb.sv
module bus_perm_filter_tb;

  localparam int NR = 8;
  localparam int AW = 4;
  localparam int RW = 4;
  localparam int A_LOCK = NR, A_FORCE = NR + 1, A_CLEAR = NR + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          rstN;
  logic [1:0]    accMaster;
  logic          accSecure, accPriv;
  logic [RW-1:0] accRegion;
  logic          accGrant;
  logic          cfgWrEn;
  logic [1:0]    cfgMaster;
  logic [AW-1:0] cfgAddr;
  logic [7:0]    cfgWrData, cfgRdData;

  bus_perm_filter u_dut (
    .clk(clk), .rstN(rstN),
    .accMaster(accMaster), .accSecure(accSecure), .accPriv(accPriv),
    .accRegion(accRegion), .accGrant(accGrant),
    .cfgWrEn(cfgWrEn), .cfgMaster(cfgMaster), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData)
  );

  int nChecks = 0;
  int nFail = 0;

  // model state from the requirements
  logic [7:0] mPerm [NR];
  logic [3:0] mLock;
  logic       mForce;

  function automatic logic [7:0] defWord(input int r);
    if (r < 2) return 8'hFF;
    if (r < 5) return 8'hFC;
    return 8'hB8;
  endfunction

  function automatic logic expGrant(input int m, input logic s, input logic p, input int r);
    logic [7:0] w;
    logic es;
    logic secOk;
    if (r >= NR) return 1'b0;
    w = mPerm[r];
    es = s && !(mForce && m == 1);
    if (es) secOk = p ? w[3] : (w[3] & w[2]);
    else    secOk = p ? w[1] : (w[1] & w[0]);
    return w[4 + m] & secOk;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic cfgWrite(input int m, input int a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgMaster = 2'(m); cfgAddr = AW'(a); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!mLock[m]) begin
      if (a < NR) mPerm[a] = d;
      else if (a == A_LOCK) mLock = mLock | d[3:0];
      else if (a == A_FORCE) mForce = d[1];
    end
  endtask

  task automatic readCheck(input string tag, input int a, input logic [7:0] exp);
    @(negedge clk);
    cfgAddr = AW'(a);
    #1;
    check(tag, cfgRdData, exp);
  endtask

  task automatic accCheck(input string tag, input int m, input logic s, input logic p,
                          input int r, input logic exp);
    @(negedge clk);
    accMaster = 2'(m); accSecure = s; accPriv = p; accRegion = RW'(r);
    #1;
    check(tag, {7'b0, accGrant}, {7'b0, exp});
  endtask

  // R1 / R3: every access combination against the model
  task automatic tSweep();
    for (int r = 0; r < 16; r++)
      for (int m = 0; m < 4; m++)
        for (int sp = 0; sp < 4; sp++)
          accCheck((r >= NR) ? "R3 out-of-range" : "R1 grant", m, sp[1], sp[0], r,
                   expGrant(m, sp[1], sp[0], r));
  endtask

  task automatic tReset();
    for (int r = 0; r < NR; r++) readCheck("R4 default", r, defWord(r));
    readCheck("R5 lock reset", A_LOCK, 8'h04);
    readCheck("R7 force reset", A_FORCE, 8'h00);
    readCheck("R9 clear reads 0", A_CLEAR, 8'h00);
    for (int a = NR + 3; a < 16; a++) readCheck("R9 unmapped", a, 8'h00);
  endtask

  task automatic tMasterMask();
    cfgWrite(0, 1, 8'h5F);
    readCheck("R9 readback", 1, 8'h5F);
    accCheck("R1 core0", 0, 1'b1, 1'b1, 1, 1'b1);
    accCheck("R1 core1", 1, 1'b1, 1'b1, 1, 1'b0);
    accCheck("R1 dma", 2, 1'b1, 1'b1, 1, 1'b1);
    accCheck("R1 debug", 3, 1'b1, 1'b1, 1, 1'b0);
  endtask

  task automatic tUnpriv();
    cfgWrite(0, 2, 8'hF4);
    accCheck("R2 SU without SP", 0, 1'b1, 1'b0, 2, 1'b0);
    accCheck("R2 SP absent", 0, 1'b1, 1'b1, 2, 1'b0);
    cfgWrite(0, 2, 8'hFC);
    accCheck("R2 SU with SP", 0, 1'b1, 1'b0, 2, 1'b1);
    cfgWrite(0, 3, 8'hF1);
    accCheck("R2 NSU without NSP", 0, 1'b0, 1'b0, 3, 1'b0);
    cfgWrite(0, 3, 8'hF3);
    accCheck("R2 NSU with NSP", 0, 1'b0, 1'b0, 3, 1'b1);
    accCheck("R2 secure denied", 0, 1'b1, 1'b1, 3, 1'b0);
  endtask

  task automatic tForce();
    cfgWrite(0, 4, 8'hF2);
    accCheck("R7 core1 secure, no force", 1, 1'b1, 1'b1, 4, 1'b0);
    cfgWrite(0, A_FORCE, 8'hFF);
    readCheck("R7 force only bit1", A_FORCE, 8'h02);
    accCheck("R7 core1 forced NS", 1, 1'b1, 1'b1, 4, 1'b1);
    accCheck("R7 core0 not forced", 0, 1'b1, 1'b1, 4, 1'b0);
    accCheck("R7 core1 loses secure", 1, 1'b1, 1'b1, 5, 1'b0);
    accCheck("R7 core0 keeps secure", 0, 1'b1, 1'b1, 5, 1'b1);
  endtask

  task automatic tClear();
    cfgWrite(0, 0, 8'h10);
    cfgWrite(0, 6, 8'h00);
    cfgWrite(0, A_CLEAR, 8'h00);
    readCheck("R8 zero write no effect", 0, 8'h10);
    cfgWrite(0, A_CLEAR, 8'h01);
    cfgAddr = AW'(0);
    #1;
    check("R8 restore one cycle later", cfgRdData, 8'h10);
    @(negedge clk);
    #1;
    check("R8 restored", cfgRdData, 8'hFF);
    for (int r = 0; r < NR; r++) mPerm[r] = defWord(r);
    readCheck("R8 region6 restored", 6, 8'hB8);
    readCheck("R8 region4 restored", 4, 8'hFC);
    readCheck("R8 lock kept", A_LOCK, 8'h04);
    readCheck("R8 force kept", A_FORCE, 8'h02);
    // restore coinciding with a permission write
    @(negedge clk);
    cfgWrEn = 1'b1; cfgMaster = 2'd0; cfgAddr = AW'(A_CLEAR); cfgWrData = 8'h01;
    @(negedge clk);
    cfgAddr = AW'(0); cfgWrData = 8'h33;
    @(negedge clk);
    cfgWrEn = 1'b0;
    readCheck("R8 restore wins", 0, 8'hFF);
    cfgWrite(0, A_FORCE, 8'h00);
    readCheck("R7 force cleared", A_FORCE, 8'h00);
  endtask

  task automatic tLock();
    cfgWrite(2, 3, 8'h00);
    readCheck("R5 dma locked perm", 3, 8'hFC);
    cfgWrite(2, A_FORCE, 8'h02);
    readCheck("R5 dma locked force", A_FORCE, 8'h00);
    cfgWrite(1, A_LOCK, 8'h02);
    readCheck("R6 lock ORed", A_LOCK, 8'h06);
    cfgWrite(1, 3, 8'h00);
    readCheck("R5 core1 locked", 3, 8'hFC);
    cfgWrite(0, A_LOCK, 8'h00);
    readCheck("R6 zero write keeps", A_LOCK, 8'h06);
    cfgWrite(3, 3, 8'h11);
    readCheck("R5 debug unlocked", 3, 8'h11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgMaster = '0; cfgAddr = '0; cfgWrData = '0;
    accMaster = '0; accSecure = 1'b0; accPriv = 1'b0; accRegion = '0;
    for (int r = 0; r < NR; r++) mPerm[r] = defWord(r);
    mLock = 4'h4;
    mForce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSweep();
    tMasterMask();
    tUnpriv();
    tForce();
    tSweep();
    tClear();
    tLock();
    tSweep();
    finishRun();
  end

endmodule